// File: doc/BRIEF.md
# Indirect-Branch Virtual-Slot Retirement Trainer

This block trains the branch prediction state after an indirect branch retires. At prediction time the front end splits each indirect branch into a chain of virtual conditional branches. The virtual address for step i is the branch address XOR a per-step hash value. The history for step i is the captured global history shifted left by i. The trainer rebuilds those same addresses and histories in order, one step per cycle. It reads the target buffer at each virtual address and sends one direction update per step. A step is trained taken only if its buffered target is the real target.

Each branch arrives with its address, its prediction-time history, its resolved target, a mispredict flag and the step at which the prediction hit. On a correct prediction, the trainer walks up to and including that step. On a misprediction, it searches for the real target. If a slot already holds it, that slot is reinforced. If the search reaches an empty slot, the target goes into that slot. If every slot is occupied by other targets, the least-used slot is replaced. The replaced slot's direction entry is trained taken in the same cycle. The block works off the critical path. It accepts a new branch only when idle. It raises `busy` while it runs and pulses `done` once when it finishes.

Top module: `vpc_retire_trainer`

## Requirements
- R1: After reset, `busy`, `done`, `dir_upd_valid`, `btb_rd_valid`, `btb_use_valid` and `btb_ins_valid` are all 0.
- R2: `ret_valid` is taken only while `busy` is 0. A `ret_valid` pulse while busy is ignored: the running walk keeps its length and no second walk follows.
- R3: The walk starts one cycle after acceptance, at step 0, and advances one step per cycle. Step i reads the target buffer and updates the direction predictor at address `ret_pc ^ hash_vals[i*PC_W +: PC_W]` with history `ret_hist << i`, zero filled.
- R4: In a walk step, `dir_upd_taken` is 1 exactly when `btb_rd_hit` is 1 and `btb_rd_target` equals the retired target. Otherwise it is 0.
- R5: With `ret_mispred` = 0, the walk visits steps 0 through `ret_iter` (capped at MAX_ITER-1) and then ends.
- R6: In any walk step whose target matches, `btb_use_valid` is 1 in that cycle and `btb_use_pc` equals that step's address. The buffer uses this to bump the slot's 2-bit saturating use counter.
- R7: With `ret_mispred` = 1, the walk ends at the first step whose target matches. That step gets a use request and no insert is issued.
- R8: With `ret_mispred` = 1, the first step that misses in the target buffer (before any match) inserts the retired target at that step's address in the same cycle. That step is trained taken and the walk ends.
- R9: With `ret_mispred` = 1 and every step hitting with a wrong target, one extra cycle follows the last step. In it, the step with the lowest `btb_rd_cnt` receives the insert and a taken update with its own address and history. On equal counts, the lowest step wins.
- R10: `done` is high for exactly one cycle, the cycle after the last update. `busy` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | A retired indirect branch is presented |
| ret_pc | input | PC_W | Address of the retired branch |
| ret_hist | input | HIST_W | Global history captured at prediction |
| ret_target | input | PC_W | Resolved target |
| ret_mispred | input | 1 | 1 when the prediction was wrong |
| ret_iter | input | ITER_W | Step at which the correct prediction hit |
| hash_vals | input | MAX_ITER*PC_W | Hash value per step, step i in lane i |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| btb_rd_valid | output | 1 | Target buffer lookup this cycle |
| btb_rd_pc | output | PC_W | Lookup address |
| btb_rd_hit | input | 1 | Lookup hit, same cycle |
| btb_rd_target | input | PC_W | Target held at the lookup address |
| btb_rd_cnt | input | CNT_W | Use counter of the looked-up entry |
| dir_upd_valid | output | 1 | Direction predictor update |
| dir_upd_pc | output | PC_W | Virtual address to update |
| dir_upd_hist | output | HIST_W | Virtual history to update |
| dir_upd_taken | output | 1 | Trained outcome |
| btb_use_valid | output | 1 | Increment use counter of an entry |
| btb_use_pc | output | PC_W | Entry to increment |
| btb_ins_valid | output | 1 | Write a new target entry |
| btb_ins_pc | output | PC_W | Address of the written entry |
| btb_ins_target | output | PC_W | Target written |

## Verification
The checks assume the target buffer answers a lookup in the same cycle and combinationally. They also assume `ret_valid` is a single-cycle pulse. The bench models the buffer as a per-step slot table that is fixed during a walk. It raises `ret_valid` only in cycles where it expects the block to be idle. The one exception is the deliberate pulse in the mid-walk-ignore test. The hash lanes are distinct, so no two steps share a virtual address, and the checks rely on this.

// File: rtl/vpct_pkg.sv
package vpct_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_INS  = 2'd2
    } vpct_state_e;

endpackage

// File: rtl/vpct_vaddr_gen.sv
module vpct_vaddr_gen #(
    parameter int PC_W     = 32,
    parameter int HIST_W   = 16,
    parameter int MAX_ITER = 4,
    parameter int ITER_W   = $clog2(MAX_ITER)
) (
    input  logic [PC_W-1:0]          base_pc,
    input  logic [HIST_W-1:0]        base_hist,
    input  logic [ITER_W-1:0]        iter,
    input  logic [MAX_ITER*PC_W-1:0] hash_vals,
    output logic [PC_W-1:0]          vpc,
    output logic [HIST_W-1:0]        vhist
);

    logic [PC_W-1:0] lane [MAX_ITER];

    for (genvar g = 0; g < MAX_ITER; g++) begin : g_lane
        assign lane[g] = hash_vals[g*PC_W +: PC_W];
    end

    assign vpc   = base_pc ^ lane[iter];
    assign vhist = base_hist << iter;

endmodule

// File: rtl/vpct_victim_pick.sv
module vpct_victim_pick #(
    parameter int ITER_W = 2,
    parameter int CNT_W  = 2
) (
    input  logic              cur_valid,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic [ITER_W-1:0] cur_iter,
    input  logic              cand_en,
    input  logic [CNT_W-1:0]  cand_cnt,
    input  logic [ITER_W-1:0] cand_iter,
    output logic              nxt_valid,
    output logic [CNT_W-1:0]  nxt_cnt,
    output logic [ITER_W-1:0] nxt_iter
);

    logic take;

    // strict compare keeps the earlier step on a tie
    assign take      = cand_en && (!cur_valid || (cand_cnt < cur_cnt));
    assign nxt_valid = cur_valid || cand_en;
    assign nxt_cnt   = take ? cand_cnt  : cur_cnt;
    assign nxt_iter  = take ? cand_iter : cur_iter;

endmodule

// File: rtl/vpc_retire_trainer.sv
module vpc_retire_trainer
    import vpct_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int HIST_W   = 16,
    parameter int MAX_ITER = 4,
    parameter int CNT_W    = 2,
    parameter int ITER_W   = $clog2(MAX_ITER)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ret_valid,
    input  logic [PC_W-1:0]          ret_pc,
    input  logic [HIST_W-1:0]        ret_hist,
    input  logic [PC_W-1:0]          ret_target,
    input  logic                     ret_mispred,
    input  logic [ITER_W-1:0]        ret_iter,
    input  logic [MAX_ITER*PC_W-1:0] hash_vals,
    output logic                     busy,
    output logic                     done,
    output logic                     btb_rd_valid,
    output logic [PC_W-1:0]          btb_rd_pc,
    input  logic                     btb_rd_hit,
    input  logic [PC_W-1:0]          btb_rd_target,
    input  logic [CNT_W-1:0]         btb_rd_cnt,
    output logic                     dir_upd_valid,
    output logic [PC_W-1:0]          dir_upd_pc,
    output logic [HIST_W-1:0]        dir_upd_hist,
    output logic                     dir_upd_taken,
    output logic                     btb_use_valid,
    output logic [PC_W-1:0]          btb_use_pc,
    output logic                     btb_ins_valid,
    output logic [PC_W-1:0]          btb_ins_pc,
    output logic [PC_W-1:0]          btb_ins_target
);

    localparam logic [ITER_W-1:0] LAST_IT = ITER_W'(MAX_ITER - 1);

    typedef struct packed {
        vpct_state_e       st;
        logic [PC_W-1:0]   pc;
        logic [HIST_W-1:0] hist;
        logic [PC_W-1:0]   tgt;
        logic              mis;
        logic [ITER_W-1:0] last;
        logic [ITER_W-1:0] iter;
        logic              vic_v;
        logic [CNT_W-1:0]  vic_cnt;
        logic [ITER_W-1:0] vic_iter;
        logic              done;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [ITER_W-1:0] gen_iter;
    logic [PC_W-1:0]   vpc;
    logic [HIST_W-1:0] vhist;
    logic              pick_v;
    logic [CNT_W-1:0]  pick_cnt;
    logic [ITER_W-1:0] pick_iter;
    logic              tgt_match;

    assign gen_iter = (ctx_q.st == ST_INS) ? ctx_q.vic_iter : ctx_q.iter;

    vpct_vaddr_gen #(
        .PC_W     (PC_W),
        .HIST_W   (HIST_W),
        .MAX_ITER (MAX_ITER),
        .ITER_W   (ITER_W)
    ) u_vaddr (
        .base_pc   (ctx_q.pc),
        .base_hist (ctx_q.hist),
        .iter      (gen_iter),
        .hash_vals (hash_vals),
        .vpc       (vpc),
        .vhist     (vhist)
    );

    vpct_victim_pick #(
        .ITER_W (ITER_W),
        .CNT_W  (CNT_W)
    ) u_pick (
        .cur_valid (ctx_q.vic_v),
        .cur_cnt   (ctx_q.vic_cnt),
        .cur_iter  (ctx_q.vic_iter),
        .cand_en   (btb_rd_hit),
        .cand_cnt  (btb_rd_cnt),
        .cand_iter (ctx_q.iter),
        .nxt_valid (pick_v),
        .nxt_cnt   (pick_cnt),
        .nxt_iter  (pick_iter)
    );

    assign tgt_match = btb_rd_hit && (btb_rd_target == ctx_q.tgt);

    always_comb begin
        ctx_d          = ctx_q;
        ctx_d.done     = 1'b0;
        btb_rd_valid   = 1'b0;
        btb_rd_pc      = vpc;
        dir_upd_valid  = 1'b0;
        dir_upd_pc     = vpc;
        dir_upd_hist   = vhist;
        dir_upd_taken  = 1'b0;
        btb_use_valid  = 1'b0;
        btb_use_pc     = vpc;
        btb_ins_valid  = 1'b0;
        btb_ins_pc     = vpc;
        btb_ins_target = ctx_q.tgt;

        unique case (ctx_q.st)
            ST_IDLE: begin
                if (ret_valid) begin
                    ctx_d.st    = ST_WALK;
                    ctx_d.pc    = ret_pc;
                    ctx_d.hist  = ret_hist;
                    ctx_d.tgt   = ret_target;
                    ctx_d.mis   = ret_mispred;
                    ctx_d.iter  = '0;
                    ctx_d.vic_v = 1'b0;
                    if (ret_mispred || (ret_iter > LAST_IT)) begin
                        ctx_d.last = LAST_IT;
                    end else begin
                        ctx_d.last = ret_iter;
                    end
                end
            end

            ST_WALK: begin
                btb_rd_valid  = 1'b1;
                dir_upd_valid = 1'b1;
                dir_upd_taken = tgt_match;
                btb_use_valid = tgt_match;
                if (!ctx_q.mis) begin
                    if (ctx_q.iter == ctx_q.last) begin
                        ctx_d.st   = ST_IDLE;
                        ctx_d.done = 1'b1;
                    end else begin
                        ctx_d.iter = ctx_q.iter + 1'b1;
                    end
                end else if (tgt_match) begin
                    ctx_d.st   = ST_IDLE;
                    ctx_d.done = 1'b1;
                end else if (!btb_rd_hit) begin
                    dir_upd_taken = 1'b1;
                    btb_ins_valid = 1'b1;
                    ctx_d.st      = ST_IDLE;
                    ctx_d.done    = 1'b1;
                end else begin
                    ctx_d.vic_v    = pick_v;
                    ctx_d.vic_cnt  = pick_cnt;
                    ctx_d.vic_iter = pick_iter;
                    if (ctx_q.iter == ctx_q.last) begin
                        ctx_d.st = ST_INS;
                    end else begin
                        ctx_d.iter = ctx_q.iter + 1'b1;
                    end
                end
            end

            ST_INS: begin
                dir_upd_valid = 1'b1;
                dir_upd_taken = 1'b1;
                btb_ins_valid = 1'b1;
                ctx_d.st      = ST_IDLE;
                ctx_d.done    = 1'b1;
            end

            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign busy = (ctx_q.st != ST_IDLE);
    assign done = ctx_q.done;

endmodule

// File: rtl/vpct_trainer_chk.sv
module vpct_trainer_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ret_valid,
    input logic            busy,
    input logic            done,
    input logic            btb_rd_valid,
    input logic            btb_rd_hit,
    input logic            dir_upd_valid,
    input logic [PC_W-1:0] dir_upd_pc,
    input logic            dir_upd_taken,
    input logic            btb_use_valid,
    input logic [PC_W-1:0] btb_use_pc,
    input logic            btb_ins_valid,
    input logic [PC_W-1:0] btb_ins_pc
);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ret_valid));

    // R1
    upd_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_upd_valid |-> busy);

    // R6
    use_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        btb_use_valid |-> (dir_upd_valid && dir_upd_taken && (btb_use_pc == dir_upd_pc)));

    // R8
    ins_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        btb_ins_valid |-> (dir_upd_valid && dir_upd_taken && (btb_ins_pc == dir_upd_pc)));

    // R7
    use_or_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({btb_use_valid, btb_ins_valid}));

    // R4
    miss_no_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (btb_rd_valid && !btb_rd_hit) |-> !btb_use_valid);

endmodule

bind vpc_retire_trainer vpct_trainer_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/sim_vpc_retire_trainer.sv
module sim_vpc_retire_trainer;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W   = 32;
    localparam int HIST_W = 16;
    localparam int NIT    = 4;
    localparam int CNT_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ret_valid = 1'b0;
    logic [PC_W-1:0]   ret_pc = '0;
    logic [HIST_W-1:0] ret_hist = '0;
    logic [PC_W-1:0]   ret_target = '0;
    logic              ret_mispred = 1'b0;
    logic [1:0]        ret_iter = '0;
    logic [NIT*PC_W-1:0] hash_vals;
    logic              busy, done;
    logic              btb_rd_valid;
    logic [PC_W-1:0]   btb_rd_pc;
    logic              btb_rd_hit;
    logic [PC_W-1:0]   btb_rd_target;
    logic [CNT_W-1:0]  btb_rd_cnt;
    logic              dir_upd_valid;
    logic [PC_W-1:0]   dir_upd_pc;
    logic [HIST_W-1:0] dir_upd_hist;
    logic              dir_upd_taken;
    logic              btb_use_valid;
    logic [PC_W-1:0]   btb_use_pc;
    logic              btb_ins_valid;
    logic [PC_W-1:0]   btb_ins_pc;
    logic [PC_W-1:0]   btb_ins_target;

    logic [PC_W-1:0]  hv [NIT];
    logic             s_hit [NIT];
    logic [PC_W-1:0]  s_tgt [NIT];
    logic [CNT_W-1:0] s_cnt [NIT];
    logic [PC_W-1:0]  cur_pc = '0;

    int tests = 0;
    int fails = 0;

    // recorded update events of one walk
    int               nev;
    logic             saw_done, done_busy, done_after;
    logic [PC_W-1:0]  ev_pc   [8];
    logic [HIST_W-1:0] ev_hist [8];
    logic             ev_tk   [8];
    logic             ev_use  [8];
    logic [PC_W-1:0]  ev_upc  [8];
    logic             ev_ins  [8];
    logic [PC_W-1:0]  ev_ipc  [8];
    logic [PC_W-1:0]  ev_itgt [8];

    assign hv[0] = 32'h0000_0000;
    assign hv[1] = 32'h1357_9bd0;
    assign hv[2] = 32'h2468_ace0;
    assign hv[3] = 32'h0f0f_1230;
    assign hash_vals = {hv[3], hv[2], hv[1], hv[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    // same-cycle target buffer model, keyed by step address
    always_comb begin
        btb_rd_hit    = 1'b0;
        btb_rd_target = '0;
        btb_rd_cnt    = '0;
        for (int i = 0; i < NIT; i++) begin
            if (btb_rd_pc == (cur_pc ^ hv[i]) && s_hit[i]) begin
                btb_rd_hit    = 1'b1;
                btb_rd_target = s_tgt[i];
                btb_rd_cnt    = s_cnt[i];
            end
        end
    end

    vpc_retire_trainer u0 (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .ret_hist(ret_hist), .ret_target(ret_target), .ret_mispred(ret_mispred),
        .ret_iter(ret_iter), .hash_vals(hash_vals), .busy(busy), .done(done),
        .btb_rd_valid(btb_rd_valid), .btb_rd_pc(btb_rd_pc), .btb_rd_hit(btb_rd_hit),
        .btb_rd_target(btb_rd_target), .btb_rd_cnt(btb_rd_cnt),
        .dir_upd_valid(dir_upd_valid), .dir_upd_pc(dir_upd_pc),
        .dir_upd_hist(dir_upd_hist), .dir_upd_taken(dir_upd_taken),
        .btb_use_valid(btb_use_valid), .btb_use_pc(btb_use_pc),
        .btb_ins_valid(btb_ins_valid), .btb_ins_pc(btb_ins_pc),
        .btb_ins_target(btb_ins_target)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_slot(input int i, input logic h, input logic [PC_W-1:0] t, input logic [CNT_W-1:0] c);
        s_hit[i] = h;
        s_tgt[i] = t;
        s_cnt[i] = c;
    endtask

    task automatic run_walk(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] hist,
                            input logic [PC_W-1:0] tgt, input logic mis, input logic [1:0] it);
        @(negedge clk);
        cur_pc = pc; ret_pc = pc; ret_hist = hist; ret_target = tgt;
        ret_mispred = mis; ret_iter = it; ret_valid = 1'b1;
        @(negedge clk);
        ret_valid = 1'b0;
        nev = 0; saw_done = 1'b0; done_busy = 1'b1; done_after = 1'b1;
        for (int k = 0; k < 12 && !saw_done; k++) begin
            if (done) begin
                saw_done  = 1'b1;
                done_busy = busy;
            end else if (dir_upd_valid && nev < 8) begin
                ev_pc[nev]   = dir_upd_pc;   ev_hist[nev] = dir_upd_hist;
                ev_tk[nev]   = dir_upd_taken;
                ev_use[nev]  = btb_use_valid; ev_upc[nev] = btb_use_pc;
                ev_ins[nev]  = btb_ins_valid; ev_ipc[nev] = btb_ins_pc;
                ev_itgt[nev] = btb_ins_target;
                nev++;
            end
            @(negedge clk);
        end
        done_after = done;
    endtask

    task automatic chk_done(input string tag);
        chk(saw_done && !done_busy, {tag, " R10 done with busy low"}, {30'd0, saw_done, done_busy}, 32'd2);
        chk(!done_after, {tag, " R10 done one cycle"}, {31'd0, done_after}, 32'd0);
    endtask

    task automatic chk_step(input int e, input int i, input logic [PC_W-1:0] pc,
                            input logic [HIST_W-1:0] hist, input logic tk);
        chk(ev_pc[e] == (pc ^ hv[i]), "R3 step address", ev_pc[e], pc ^ hv[i]);
        chk(ev_hist[e] == HIST_W'(hist << i), "R3 step history", {16'd0, ev_hist[e]}, {16'd0, HIST_W'(hist << i)});
        chk(ev_tk[e] == tk, "R4 trained outcome", {31'd0, ev_tk[e]}, {31'd0, tk});
    endtask

    task automatic t_reset;
        chk(!busy && !done, "R1 busy/done at reset", {30'd0, busy, done}, 32'd0);
        chk(!dir_upd_valid && !btb_rd_valid && !btb_use_valid && !btb_ins_valid, "R1 requests at reset",
            {28'd0, dir_upd_valid, btb_rd_valid, btb_use_valid, btb_ins_valid}, 32'd0);
    endtask

    task automatic t_correct_mid;
        logic [PC_W-1:0] pc = 32'h0040_1000;
        set_slot(0, 1, 32'hA0, 1); set_slot(1, 1, 32'hA1, 2);
        set_slot(2, 1, 32'hBEEF, 0); set_slot(3, 1, 32'hA3, 3);
        run_walk(pc, 16'h5a5a, 32'hBEEF, 1'b0, 2'd2);
        chk(nev == 3, "R5 correct walk length", nev, 3);
        chk_step(0, 0, pc, 16'h5a5a, 1'b0);
        chk_step(1, 1, pc, 16'h5a5a, 1'b0);
        chk_step(2, 2, pc, 16'h5a5a, 1'b1);
        chk(ev_use[2] && ev_upc[2] == (pc ^ hv[2]), "R6 use request at hit step", ev_upc[2], pc ^ hv[2]);
        chk(!ev_use[0] && !ev_use[1] && !ev_ins[2], "R6 no use on wrong steps", {30'd0, ev_use[0], ev_use[1]}, 32'd0);
        chk_done("correct_mid");
    endtask

    task automatic t_correct_first;
        logic [PC_W-1:0] pc = 32'h0080_2340;
        set_slot(0, 1, 32'h1234, 0); set_slot(1, 1, 32'hA1, 2);
        set_slot(2, 1, 32'hA2, 0); set_slot(3, 0, 32'h0, 0);
        run_walk(pc, 16'h8001, 32'h1234, 1'b0, 2'd0);
        chk(nev == 1, "R5 walk ends at step 0", nev, 1);
        chk_step(0, 0, pc, 16'h8001, 1'b1);
        chk(ev_use[0], "R6 use at step 0", {31'd0, ev_use[0]}, 1);
        chk_done("correct_first");
    endtask

    task automatic t_mis_match;
        logic [PC_W-1:0] pc = 32'h00c0_0100;
        set_slot(0, 1, 32'hB0, 3); set_slot(1, 1, 32'h7777, 1);
        set_slot(2, 0, 32'h0, 0); set_slot(3, 1, 32'hB3, 0);
        run_walk(pc, 16'h00f3, 32'h7777, 1'b1, 2'd0);
        chk(nev == 2, "R7 mispredict walk stops at match", nev, 2);
        chk_step(0, 0, pc, 16'h00f3, 1'b0);
        chk_step(1, 1, pc, 16'h00f3, 1'b1);
        chk(ev_use[1] && !ev_ins[1] && !ev_ins[0], "R7 use and no insert", {30'd0, ev_use[1], ev_ins[1]}, 32'd2);
        chk_done("mis_match");
    endtask

    task automatic t_mis_free;
        logic [PC_W-1:0] pc = 32'h0100_0440;
        set_slot(0, 1, 32'hC0, 0); set_slot(1, 1, 32'hC1, 0);
        set_slot(2, 0, 32'h0, 0); set_slot(3, 1, 32'hC3, 0);
        run_walk(pc, 16'h1111, 32'h9999, 1'b1, 2'd3);
        chk(nev == 3, "R8 walk stops at free slot", nev, 3);
        chk_step(2, 2, pc, 16'h1111, 1'b1);
        chk(ev_ins[2] && ev_ipc[2] == (pc ^ hv[2]), "R8 insert address", ev_ipc[2], pc ^ hv[2]);
        chk(ev_itgt[2] == 32'h9999, "R8 insert target", ev_itgt[2], 32'h9999);
        chk(!ev_ins[0] && !ev_ins[1] && !ev_tk[1], "R8 earlier steps not taken", {30'd0, ev_ins[1], ev_tk[1]}, 32'd0);
        chk_done("mis_free");
    endtask

    task automatic t_mis_lfu;
        logic [PC_W-1:0] pc = 32'h0200_0800;
        set_slot(0, 1, 32'hD0, 3); set_slot(1, 1, 32'hD1, 1);
        set_slot(2, 1, 32'hD2, 2); set_slot(3, 1, 32'hD3, 1);
        run_walk(pc, 16'hffff, 32'h4242, 1'b1, 2'd0);
        chk(nev == 5, "R9 four steps plus insert", nev, 5);
        chk_step(3, 3, pc, 16'hffff, 1'b0);
        chk_step(4, 1, pc, 16'hffff, 1'b1);
        chk(ev_ins[4] && ev_ipc[4] == (pc ^ hv[1]), "R9 lowest count victim, tie to lower step", ev_ipc[4], pc ^ hv[1]);
        chk(ev_itgt[4] == 32'h4242, "R9 insert target", ev_itgt[4], 32'h4242);
        chk_done("mis_lfu");
    endtask

    task automatic t_mis_tie;
        logic [PC_W-1:0] pc = 32'h0300_0c00;
        set_slot(0, 1, 32'hE0, 2); set_slot(1, 1, 32'hE1, 2);
        set_slot(2, 1, 32'hE2, 2); set_slot(3, 1, 32'hE3, 2);
        run_walk(pc, 16'h0003, 32'h5151, 1'b1, 2'd0);
        chk(nev == 5, "R9 equal counts walk length", nev, 5);
        chk_step(4, 0, pc, 16'h0003, 1'b1);
        chk(ev_ins[4] && ev_ipc[4] == pc, "R9 equal counts pick step 0", ev_ipc[4], pc);
        chk_done("mis_tie");
    endtask

    task automatic t_ignore_busy;
        int cnt;
        logic extra;
        set_slot(0, 1, 32'hF0, 1); set_slot(1, 1, 32'hF1, 1);
        set_slot(2, 1, 32'hF2, 1); set_slot(3, 1, 32'hF3, 1);
        @(negedge clk);
        cur_pc = 32'h0400_0000; ret_pc = cur_pc; ret_hist = 16'h0101;
        ret_target = 32'h6060; ret_mispred = 1'b1; ret_valid = 1'b1;
        @(negedge clk);
        ret_pc = 32'h0500_0000; ret_mispred = 1'b0; ret_iter = 2'd0;
        cnt = 0; extra = 1'b0;
        for (int k = 0; k < 12 && !done; k++) begin
            if (dir_upd_valid) cnt++;
            if (k == 1) ret_valid = 1'b0;
            @(negedge clk);
        end
        ret_valid = 1'b0;
        chk(cnt == 5, "R2 walk not restarted by pulse while busy", cnt, 5);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (busy || dir_upd_valid) extra = 1'b1;
        end
        chk(!extra, "R2 no second walk after ignored pulse", {31'd0, extra}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        tests++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NIT; i++) set_slot(i, 0, '0, '0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_correct_mid();
        t_correct_first();
        t_mis_match();
        t_mis_free();
        t_mis_lfu();
        t_mis_tie();
        t_ignore_busy();
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule